// File: doc/BRIEF.md
# Indexed Clock-Synthesizer Parameter Bank

This block sits on a host register bus and gives indirect access to the divider settings of three independent clock synthesizers: pixel, memory and loop. A single shared address register holds one 2-bit sub-pointer per synthesizer. Each synthesizer has its own data port. The sub-pointer selects which of that synthesizer's four internal registers the data port reaches: N, M, P or a read-only status word. The stored N, M and P values are driven continuously to the synthesizers. A test-output enable is taken from the pixel synthesizer's P value.

To program a synthesizer, the host clears its sub-pointer and then writes N, M and P through the data port. Each write advances that port's sub-pointer, so after the three writes the pointer rests on status. The host can then poll status for the lock flag, because reads never move a pointer. The analog loops and the lock detectors sit outside this block. Only their lock indications come in, and they pass through a two-flop synchronizer.

Top module: `pll_param_bank`

## Requirements
- R1: Index 0x2C selects the address register. Indices 0x2D, 0x2E and 0x2F select the data ports of the pixel, memory and loop synthesizers (slots 0, 1 and 2).
- R2: In the address register, bits 1:0 hold the slot 0 sub-pointer, bits 3:2 the slot 1 sub-pointer and bits 5:4 the slot 2 sub-pointer. A write loads all three fields, and a read returns their present values.
- R3: A sub-pointer code of 0 selects N, 1 selects M, 2 selects P and 3 selects status. A data-port read returns the selected register, and a data-port write stores into it.
- R4: A write to a data port increments only that slot's sub-pointer, and the pointer wraps from 3 to 0. The other two pointers are unchanged.
- R5: A read of a data port or of the address register leaves every sub-pointer unchanged.
- R6: A data-port write while the pointer is at status changes none of the stored N, M or P values.
- R7: The status word carries the slot's lock input in bit 6 and zeros in all other bits. The lock input is seen in status after two rising edges of the host clock, and not after one.
- R8: Address register bits 7:6 read as zero. A read of any index other than 0x2C to 0x2F returns zero, and a write to such an index changes no pointer or stored value.
- R9: Outputs n_o, m_o and p_o carry each slot's stored values, with slot k in bits 8k+7:8k. pix_test_en_o equals bit 6 of the slot 0 P value.
- R10: rdata_o is zero whenever rd_i is low. After reset, all pointers and stored values are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| idx_i | input | 8 | Register index |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe, sampled on the rising edge |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data, combinational |
| lock_i | input | 3 | Lock flags from the synthesizers, asynchronous |
| n_o | output | 24 | Stored N values, one byte per slot |
| m_o | output | 24 | Stored M values, one byte per slot |
| p_o | output | 24 | Stored P values, one byte per slot |
| pix_test_en_o | output | 1 | Pixel clock test-output enable |

## Verification
The bench sweeps every slot from every starting pointer through five successive writes and compares against a bench model after each write. This catches four kinds of fault: a design that advanced the wrong pointer or all pointers, a design that missed the wrap from 3 to 0, and a design that let a write at status corrupt N, M or P. It reads each data port repeatedly, so a pointer that moved on reads would show up. A full sweep of unmapped indices writes and reads every one, which exposes address decoding that aliases onto a live register. The lock flag is sampled after one edge and again after two, so a synchronizer with the wrong depth shows the flag too early or too late.

// File: rtl/pll_bank_pkg.sv
package pll_bank_pkg;
  typedef enum logic [1:0] {
    PTR_N    = 2'd0,
    PTR_M    = 2'd1,
    PTR_P    = 2'd2,
    PTR_STAT = 2'd3
  } ptr_sel_e;

  localparam int PTR_W       = 2;
  localparam int LOCK_BIT    = 6;
  localparam int TEST_EN_BIT = 6;
endpackage

// File: rtl/pll_lock_sync.sv
module pll_lock_sync #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/pll_param_slot.sv
module pll_param_slot
  import pll_bank_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ptr_we_i,
  input  logic [PTR_W-1:0] ptr_wdata_i,
  input  logic             data_we_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             lock_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic [DW-1:0]    n_o,
  output logic [DW-1:0]    m_o,
  output logic [DW-1:0]    p_o,
  output logic [DW-1:0]    rdata_o
);
  logic [PTR_W-1:0] ptr_q;
  logic [DW-1:0]    n_q, m_q, p_q, stat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (ptr_we_i) begin
      ptr_q <= ptr_wdata_i;
    end else if (data_we_i) begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_q <= '0;
      m_q <= '0;
      p_q <= '0;
    end else if (data_we_i) begin
      case (ptr_q)
        PTR_N:   n_q <= wdata_i;
        PTR_M:   m_q <= wdata_i;
        PTR_P:   p_q <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    stat           = '0;
    stat[LOCK_BIT] = lock_i;
  end

  always_comb begin
    case (ptr_q)
      PTR_N:   rdata_o = n_q;
      PTR_M:   rdata_o = m_q;
      PTR_P:   rdata_o = p_q;
      default: rdata_o = stat;
    endcase
  end

  assign ptr_o = ptr_q;
  assign n_o   = n_q;
  assign m_o   = m_q;
  assign p_o   = p_q;

  AST_PTR_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_we_i && !ptr_we_i) |=> ptr_q == $past(ptr_q) + 2'd1); // R4
  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!data_we_i && !ptr_we_i) |=> $stable(ptr_q)); // R5
  AST_STAT_NO_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_we_i && ptr_q == PTR_STAT) |=> ($stable(n_q) && $stable(m_q) && $stable(p_q))); // R6
endmodule

// File: rtl/pll_param_bank.sv
module pll_param_bank
  import pll_bank_pkg::*;
#(
  parameter int         DW       = 8,
  parameter int         IW       = 8,
  parameter int         NUM_PLL  = 3,
  parameter logic [7:0] BASE_IDX = 8'h2C
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [IW-1:0]         idx_i,
  input  logic [DW-1:0]         wdata_i,
  input  logic                  wr_i,
  input  logic                  rd_i,
  output logic [DW-1:0]         rdata_o,
  input  logic [NUM_PLL-1:0]    lock_i,
  output logic [NUM_PLL*DW-1:0] n_o,
  output logic [NUM_PLL*DW-1:0] m_o,
  output logic [NUM_PLL*DW-1:0] p_o,
  output logic                  pix_test_en_o
);
  localparam int AW = PTR_W * NUM_PLL;
  localparam logic [IW-1:0] ADDR_IDX = IW'(BASE_IDX);

  logic [NUM_PLL-1:0] lock_sync, port_hit;
  logic [AW-1:0]      ptr_flat;
  logic [DW-1:0]      slot_rdata [NUM_PLL];
  logic               addr_hit;

  assign addr_hit = (idx_i == ADDR_IDX);

  pll_lock_sync #(.W(NUM_PLL)) i_lock_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (lock_i),
    .sync_o  (lock_sync)
  );

  for (genvar k = 0; k < NUM_PLL; k++) begin : g_slot
    localparam logic [IW-1:0] PORT_IDX = ADDR_IDX + IW'(k + 1);
    assign port_hit[k] = (idx_i == PORT_IDX);

    pll_param_slot #(.DW(DW)) i_slot (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .ptr_we_i    (wr_i && addr_hit),
      .ptr_wdata_i (wdata_i[PTR_W*k +: PTR_W]),
      .data_we_i   (wr_i && port_hit[k]),
      .wdata_i     (wdata_i),
      .lock_i      (lock_sync[k]),
      .ptr_o       (ptr_flat[PTR_W*k +: PTR_W]),
      .n_o         (n_o[DW*k +: DW]),
      .m_o         (m_o[DW*k +: DW]),
      .p_o         (p_o[DW*k +: DW]),
      .rdata_o     (slot_rdata[k])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (addr_hit) rdata_o[AW-1:0] = ptr_flat;
      for (int k = 0; k < NUM_PLL; k++) begin
        if (port_hit[k]) rdata_o = slot_rdata[k];
      end
    end
  end

  assign pix_test_en_o = p_o[TEST_EN_BIT];

  AST_ADDR_TOP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_hit) |-> rdata_o[DW-1:AW] == '0); // R8
  AST_RD_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> rdata_o == '0); // R10
endmodule

// File: tb/test_pll_param_bank.sv
module test_pll_param_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  idx = '0, wdata = '0, rdata;
  logic        wr = 1'b0, rd = 1'b0;
  logic [2:0]  lock = '0;
  logic [23:0] n_out, m_out, p_out;
  logic        test_en;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic [7:0] mdl_n [NP];
  logic [7:0] mdl_m [NP];
  logic [7:0] mdl_p [NP];
  logic [1:0] mdl_ptr [NP];

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_param_bank i_pll_param_bank (
    .clk_i(clk), .rst_ni(rst_n), .idx_i(idx), .wdata_i(wdata), .wr_i(wr), .rd_i(rd),
    .rdata_o(rdata), .lock_i(lock), .n_o(n_out), .m_o(m_out), .p_o(p_out),
    .pix_test_en_o(test_en)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] i, input logic [7:0] d);
    @(negedge clk);
    idx = i; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    if (i == 8'h2C) begin
      for (int k = 0; k < NP; k++) mdl_ptr[k] = d[2*k +: 2];
    end else if (i >= 8'h2D && i <= 8'h2F) begin
      int k = int'(i - 8'h2D);
      case (mdl_ptr[k])
        2'd0: mdl_n[k] = d;
        2'd1: mdl_m[k] = d;
        2'd2: mdl_p[k] = d;
        default: ;
      endcase
      mdl_ptr[k] = mdl_ptr[k] + 2'd1;
    end
  endtask

  task automatic rd_reg(input logic [7:0] i, output logic [7:0] v);
    @(negedge clk);
    idx = i; rd = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  function automatic logic [7:0] exp_data(input int k);
    case (mdl_ptr[k])
      2'd0: return mdl_n[k];
      2'd1: return mdl_m[k];
      2'd2: return mdl_p[k];
      default: return {1'b0, lock[k], 6'b0};
    endcase
  endfunction

  function automatic logic [7:0] exp_addr();
    return {2'b00, mdl_ptr[2], mdl_ptr[1], mdl_ptr[0]};
  endfunction

  task automatic chk_outputs(input string tag);
    for (int k = 0; k < NP; k++) begin
      chk(n_out[8*k +: 8], mdl_n[k], {tag, " R9 n"});
      chk(m_out[8*k +: 8], mdl_m[k], {tag, " R9 m"});
      chk(p_out[8*k +: 8], mdl_p[k], {tag, " R9 p"});
    end
    chk(test_en, mdl_p[0][6], {tag, " R9 test_en"});
  endtask

  task automatic set_ptr(input int k, input logic [1:0] v);
    logic [7:0] a;
    a = exp_addr();
    a[2*k +: 2] = v;
    wr_reg(8'h2C, a);
  endtask

  initial begin
    logic [7:0] v;
    for (int k = 0; k < NP; k++) begin
      mdl_n[k] = '0; mdl_m[k] = '0; mdl_p[k] = '0; mdl_ptr[k] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state and idle read
    chk_outputs("reset R10");
    chk(rdata, 8'h00, "R10 idle rdata");
    idx = 8'h2D; #1 chk(rdata, 8'h00, "R10 rd low on data port");

    // R1 R2 R3 standard program sequence per slot
    for (int k = 0; k < NP; k++) begin
      set_ptr(k, 2'd0);
      wr_reg(8'h2D + 8'(k), 8'(8'h11 * (k + 1)));
      wr_reg(8'h2D + 8'(k), 8'(8'h40 + k));
      wr_reg(8'h2D + 8'(k), 8'(8'hC3 - k));
      rd_reg(8'h2C, v); chk(v, exp_addr(), "R1 R2 R4 pointer after load");
      chk(mdl_ptr[k], 2'd3, "R3 rests on status");
      rd_reg(8'h2D + 8'(k), v); chk(v, 8'h00, "R7 status lock low");
      rd_reg(8'h2D + 8'(k), v); chk(v, 8'h00, "R5 repeated status poll");
      chk_outputs("R3 load");
    end

    // R4 R5 R6 sweep every slot from every start pointer
    for (int k = 0; k < NP; k++) begin
      for (int s = 0; s < 4; s++) begin
        set_ptr(k, 2'(s));
        rd_reg(8'h2C, v); chk(v, exp_addr(), "R2 address readback");
        for (int j = 0; j < 5; j++) begin
          rd_reg(8'h2D + 8'(k), v); chk(v, exp_data(k), "R3 data read");
          rd_reg(8'h2D + 8'(k), v); chk(v, exp_data(k), "R5 reread same register");
          wr_reg(8'h2D + 8'(k), 8'((k * 37 + s * 11 + j * 5) ^ 8'hA5));
          rd_reg(8'h2C, v); chk(v, exp_addr(), "R4 only own pointer moves, wraps");
          chk_outputs("R6 R9 after write");
        end
      end
    end

    // R2 set all pointers at once, upper bits ignored
    wr_reg(8'h2C, 8'hE4);
    rd_reg(8'h2C, v); chk(v, 8'h24, "R8 upper address bits read zero");
    chk(exp_addr(), 8'h24, "R2 field layout");
    for (int k = 0; k < NP; k++) begin
      rd_reg(8'h2D + 8'(k), v); chk(v, exp_data(k), "R2 R3 per-field select");
    end

    // R7 lock synchronization depth
    for (int k = 0; k < NP; k++) set_ptr(k, 2'd3);
    @(negedge clk);
    lock = 3'b101;
    idx = 8'h2D; rd = 1'b1;
    @(negedge clk); #1 chk(rdata, 8'h00, "R7 lock not seen after one edge");
    @(negedge clk); #1 chk(rdata, 8'h40, "R7 lock seen after two edges");
    idx = 8'h2E; #1 chk(rdata, 8'h00, "R7 slot1 lock low");
    idx = 8'h2F; #1 chk(rdata, 8'h40, "R7 slot2 lock high");
    rd = 1'b0;
    @(negedge clk);
    chk(mdl_ptr[0], 2'd3, "R7 setup");
    wr_reg(8'h2D, 8'hFF);
    chk_outputs("R6 write at status");
    rd_reg(8'h2C, v); chk(v, exp_addr(), "R4 wrap from status");

    // R8 unmapped index sweep
    for (int i = 0; i < 256; i++) begin
      if (i >= 8'h2C && i <= 8'h2F) continue;
      wr_reg(8'(i), 8'(i) ^ 8'h5A);
      rd_reg(8'(i), v);
      if (v !== 8'h00) chk(v, 8'h00, "R8 unmapped read");
    end
    n_run++;
    chk_outputs("R8 unmapped writes");
    rd_reg(8'h2C, v); chk(v, exp_addr(), "R8 pointers untouched");

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule